// File: doc/BRIEF.md
# Nine-Bit Multi-Drop Serial Transceiver

This block sends and receives asynchronous serial frames that carry a ninth bit next to each 8-bit data byte. On a multi-drop bus, one master addresses several slaves, and it marks address frames by setting the ninth bit. The block is written for the slave side. It has a register-style interface that covers the operating mode, the outgoing ninth bit, the transmit byte, the stop length, the wake-up enable, and the received byte and ninth bit. It also has a receive-interrupt pulse.

A transmission starts when the transmit byte is written. At that write the block captures the ninth bit and the stop length from their fields, so software sets those fields first. The frame is:

- a low start bit,
- eight data bits, least significant first,
- the ninth bit,
- one or two high stop bits.

The transmit pin is open drain. The block only ever pulls the line low, and a pull-up holds it high otherwise, so several slaves can share one return line.

The receiver oversamples the line 16 times per bit, using a baud-tick enable. When wake-up filtering is enabled, the receiver drops every frame whose ninth bit is 0. This keeps a slave quiet through data traffic meant for other slaves until the next address frame arrives.

Top module: `nbit_uart`

## Requirements
- R1: The block runs only while `mode_sel` equals binary 11. In any other mode:
  - a `tx_wr` strobe starts nothing: `tx_busy` and `txd_oe` stay 0;
  - frames arriving on `rxd` leave `rx_data` and `rx_bit9` unchanged and raise no `rx_irq`.
- R2: A transmitted frame, in line order, is:
  - a start bit at 0,
  - `tx_data` bits 0 to 7,
  - the `tx_bit9` value captured at the write,
  - stop bits at 1.

  Each bit lasts 16 baud ticks. `txd_oe` is 1 exactly while the line is driven to 0, and it is 0 whenever `tx_busy` is 0.
- R3: When `stop_two` is 0 at the write, `tx_busy` lasts 11 bit times (one stop bit). When it is 1, `tx_busy` lasts 12 bit times.
- R4: An accepted frame loads its eight data bits into `rx_data` and its ninth bit into `rx_bit9`. Both fields hold their values between accepted frames and reset to 0.
- R5: With `wake_en` at 0, every frame with a high stop bit is accepted, whatever its ninth bit. Acceptance gives a one-cycle `rx_irq` pulse.
- R6: With `wake_en` at 1, a frame is accepted only if its ninth bit is 1. A frame whose ninth bit is 0 raises no `rx_irq` and leaves `rx_data` and `rx_bit9` unchanged.
- R7: A frame whose stop bit samples low gives a one-cycle `frame_err` pulse. It is not accepted: no `rx_irq`, and the receive fields are unchanged.
- R8: The receiver checks the start bit again half a bit after the falling edge. A low pulse shorter than half a bit starts no frame and raises neither `rx_irq` nor `frame_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable, 16 per bit time |
| mode_sel | input | 2 | Operating mode; 2'b11 selects nine-bit operation |
| wake_en | input | 1 | Accept only frames whose ninth bit is 1 |
| stop_two | input | 1 | 0: one stop bit, 1: two stop bits (captured at write) |
| tx_bit9 | input | 1 | Ninth bit for the next transmit (captured at write) |
| tx_wr | input | 1 | Transmit byte write strobe; starts a frame |
| tx_data | input | 8 | Transmit byte |
| tx_busy | output | 1 | A frame is being sent |
| txd_oe | output | 1 | Open-drain pull-down enable for the transmit line |
| rxd | input | 1 | Receive line (asynchronous) |
| rx_data | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_irq | output | 1 | One-cycle pulse per accepted frame |
| frame_err | output | 1 | One-cycle pulse per frame with a low stop bit |

## Verification
Each kind of internal fault shows up at the ports in its own way and at its own time:

- A bit counter or sample phase that drifts in the receiver shows up one frame later as a wrong byte or ninth bit in the scoreboard, or as a missing interrupt.
- A transmit shift or stop-count error appears on `txd_oe` within the same bit time, at the mid-bit sample, or as a `tx_busy` length that is off by a whole bit.
- A faulty acceptance gate is visible straight away. An interrupt arrives for a data frame in wake-up mode, or the receive fields change after a frame that should have been dropped.

// File: rtl/nbu_pkg.sv
package nbu_pkg;
  localparam logic [1:0] MODE_NINE = 2'b11;

  // bits in a frame: start + data + ninth + stop(s)
  function automatic int unsigned frame_bits(input int unsigned dw, input logic two);
    return dw + 3 + (two ? 1 : 0);
  endfunction

  function automatic logic accept_frame(input logic ok, input logic wake, input logic b9);
    return ok && (!wake || b9);
  endfunction
endpackage

// File: rtl/nbu_sync.sv
module nbu_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= {STAGES{RST_VAL}};
        else        r <= {r[STAGES-2:0], d};
    end
  endgenerate

  assign q = r[STAGES-1];
endmodule

// File: rtl/nbu_tx.sv
module nbu_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          bit9,
  input  logic          stop_two,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          line
);
  localparam int FW = DW + 4;
  localparam int CW = $clog2(OVS);
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0] frm;
  logic [LW-1:0] left;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm  <= '1;
      left <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start && !busy) begin
      frm  <= {2'b11, bit9, data, 1'b0};
      left <= LW'(nbu_pkg::frame_bits(DW, stop_two));
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy && tick) begin
      if (cnt == CW'(OVS - 1)) begin
        cnt  <= '0;
        frm  <= {1'b1, frm[FW-1:1]};
        left <= left - 1'b1;
        if (left == LW'(1)) busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign line = busy ? frm[0] : 1'b1;
endmodule

// File: rtl/nbu_rx.sv
module nbu_rx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        en,
  input  logic        rxs,
  output logic        ok,
  output logic        bad,
  output logic [DW:0] word
);
  localparam int CW   = $clog2(OVS);
  localparam int IW   = $clog2(DW + 2);
  localparam int HALF = OVS / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_st_t;

  rx_st_t        st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW:0]   sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= RX_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
      ok  <= 1'b0;
      bad <= 1'b0;
    end else if (!en) begin
      st  <= RX_IDLE;
      ok  <= 1'b0;
      bad <= 1'b0;
    end else begin
      ok  <= 1'b0;
      bad <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: if (!rxs) begin
            st  <= RX_START;
            cnt <= '0;
          end
          RX_START: if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            idx <= '0;
            st  <= rxs ? RX_IDLE : RX_BITS;
          end else cnt <= cnt + 1'b1;
          RX_BITS: if (cnt == CW'(OVS - 1)) begin
            cnt <= '0;
            sh  <= {rxs, sh[DW:1]};
            if (idx == IW'(DW)) st <= RX_STOP;
            else                idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
          RX_STOP: if (cnt == CW'(OVS - 1)) begin
            cnt <= '0;
            st  <= RX_IDLE;
            ok  <= rxs;
            bad <= !rxs;
          end else cnt <= cnt + 1'b1;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assign word = sh;
endmodule

// File: rtl/nbit_uart.sv
module nbit_uart #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic [1:0]    mode_sel,
  input  logic          wake_en,
  input  logic          stop_two,
  input  logic          tx_bit9,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  output logic          tx_busy,
  output logic          txd_oe,
  input  logic          rxd,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_irq,
  output logic          frame_err
);
  logic          run_en;
  logic          tx_line;
  logic          rx_sync;
  logic          rx_ok;
  logic          rx_bad;
  logic [DW:0]   rx_word;
  logic          rx_accept;

  assign run_en = (mode_sel == nbu_pkg::MODE_NINE);

  nbu_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_sync)
  );

  nbu_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .start(tx_wr && run_en), .bit9(tx_bit9), .stop_two(stop_two),
    .data(tx_data), .busy(tx_busy), .line(tx_line)
  );

  nbu_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(run_en),
    .rxs(rx_sync), .ok(rx_ok), .bad(rx_bad), .word(rx_word)
  );

  // open drain: enable the pull-down only while sending a zero
  assign txd_oe    = !tx_line;
  assign rx_accept = nbu_pkg::accept_frame(rx_ok, wake_en, rx_word[DW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_bit9   <= 1'b0;
      rx_irq    <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_irq    <= rx_accept;
      frame_err <= rx_bad;
      if (rx_accept) begin
        rx_data <= rx_word[DW-1:0];
        rx_bit9 <= rx_word[DW];
      end
    end
  end
endmodule

// File: rtl/nbu_chk.sv
module nbu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_sel,
  input logic          tx_wr,
  input logic          tx_busy,
  input logic          txd_oe,
  input logic          wake_en,
  input logic          rx_irq,
  input logic          rx_bit9,
  input logic [DW-1:0] rx_data,
  input logic          frame_err,
  input logic          rx_accept
);
  AST_MODE_TX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !(mode_sel == 2'b11 && tx_wr)) |=> !tx_busy);  // R1
  AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !txd_oe);  // R2
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_accept) |-> ($stable(rx_data) && $stable(rx_bit9)));  // R4
  AST_WAKE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && $past(wake_en)) |-> rx_bit9);  // R6
  AST_ERR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !rx_irq);  // R7
endmodule

bind nbit_uart nbu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tx_wr(tx_wr),
  .tx_busy(tx_busy), .txd_oe(txd_oe), .wake_en(wake_en),
  .rx_irq(rx_irq), .rx_bit9(rx_bit9), .rx_data(rx_data),
  .frame_err(frame_err), .rx_accept(rx_accept)
);

// File: tb/sim_nbit_uart.sv
`timescale 1ns/1ps
module sim_nbit_uart;
  localparam int BITC = 32;  // clocks per bit: tick every 2 clocks, 16 ticks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       wake_en = 1'b0, stop_two = 1'b0, tx_bit9 = 1'b0, tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_busy, txd_oe, rx_bit9, rx_irq, frame_err;
  logic [7:0] rx_data;
  logic       bench_line = 1'b1;
  wire        rxd = bench_line & ~txd_oe;

  int n_chk = 0, n_fail = 0, err_seen = 0, cyc = 0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;
  always @(negedge clk) baud_tick <= ~baud_tick;

  nbit_uart u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode_sel(mode_sel),
    .wake_en(wake_en), .stop_two(stop_two), .tx_bit9(tx_bit9), .tx_wr(tx_wr),
    .tx_data(tx_data), .tx_busy(tx_busy), .txd_oe(txd_oe), .rxd(rxd),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_irq(rx_irq), .frame_err(frame_err)
  );

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_irq) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected rx_irq", {rx_bit9, rx_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({rx_bit9, rx_data} == e, "R4 received word", {rx_bit9, rx_data}, e);
        end
      end
      if (frame_err) err_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  function automatic bit will_accept(input logic b9);
    return (mode_sel == 2'b11) && (!wake_en || b9);
  endfunction

  // drive a frame onto the shared line from the bench side
  task automatic drive_frame(input logic b9, input logic [7:0] d, input bit good_stop);
    logic [10:0] f;
    f = {good_stop, b9, d, 1'b0};
    if (good_stop && will_accept(b9)) exp_q.push_back({b9, d});
    for (int k = 0; k < 11; k++) begin
      bench_line = f[k];
      repeat (BITC) @(negedge clk);
    end
    bench_line = 1'b1;
    repeat (2 * BITC) @(negedge clk);
  endtask

  // transmit through the block, check line bits and frame length
  task automatic send_tx(input logic b9, input logic [7:0] d, input logic two);
    logic [10:0] f;
    int i, n;
    f = {1'b1, b9, d, 1'b0};
    n = two ? 12 : 11;
    if (will_accept(b9)) exp_q.push_back({b9, d});
    tx_bit9 = b9; stop_two = two; tx_data = d; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    chk(txd_oe == 1'b1, "R2 start bit drives low", txd_oe, 1);
    i = 0;
    while (tx_busy && i < 1000) begin
      if (i % BITC == 16 && i / BITC <= 10)
        chk(txd_oe == ~f[i / BITC], "R2 frame bit", txd_oe, ~f[i / BITC]);
      @(negedge clk);
      i++;
    end
    chk(i >= BITC * n - 2 && i <= BITC * n + 1, "R3 busy length", i, BITC * n);
    chk(txd_oe == 1'b0, "R2 released after frame", txd_oe, 0);
    repeat (2 * BITC) @(negedge clk);
  endtask

  initial begin
    int busy_seen;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_busy && !txd_oe, "R2 reset idle", {tx_busy, txd_oe}, 0);
    chk(rx_data == 0 && !rx_bit9, "R4 reset fields", {rx_bit9, rx_data}, 0);
    chk(!rx_irq && !frame_err, "R5 reset pulses", {rx_irq, frame_err}, 0);

    // R1: other mode ignores write and line
    tx_data = 8'h77; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    busy_seen = 0;
    repeat (40) begin
      if (tx_busy || txd_oe) busy_seen++;
      @(negedge clk);
    end
    chk(busy_seen == 0, "R1 write ignored outside mode", busy_seen, 0);
    drive_frame(1'b1, 8'h44, 1'b1);
    chk(rx_data == 0 && !rx_bit9, "R1 receive ignored outside mode", {rx_bit9, rx_data}, 0);

    mode_sel = 2'b11;
    // R2 R3 with loopback into R4 R5
    send_tx(1'b1, 8'hA5, 1'b0);
    send_tx(1'b0, 8'h3C, 1'b1);
    chk(rx_data == 8'h3C && !rx_bit9, "R5 loopback ninth bit 0", {rx_bit9, rx_data}, 9'h03C);

    // R5: wake off, both ninth bit values
    drive_frame(1'b0, 8'h5A, 1'b1);
    drive_frame(1'b1, 8'hFF, 1'b1);
    chk(rx_data == 8'hFF && rx_bit9, "R5 fields after frame", {rx_bit9, rx_data}, 9'h1FF);

    // R6: wake filter
    wake_en = 1'b1;
    drive_frame(1'b0, 8'h12, 1'b1);
    chk(rx_data == 8'hFF && rx_bit9, "R6 data frame dropped", {rx_bit9, rx_data}, 9'h1FF);
    drive_frame(1'b1, 8'h81, 1'b1);
    chk(rx_data == 8'h81 && rx_bit9, "R6 address frame taken", {rx_bit9, rx_data}, 9'h181);
    wake_en = 1'b0;

    // R7: low stop bit
    drive_frame(1'b0, 8'h66, 1'b0);
    chk(err_seen == 1, "R7 frame_err pulses", err_seen, 1);
    chk(rx_data == 8'h81 && rx_bit9, "R7 fields unchanged", {rx_bit9, rx_data}, 9'h181);

    // R8: short glitch
    bench_line = 1'b0;
    repeat (8) @(negedge clk);
    bench_line = 1'b1;
    repeat (14 * BITC) @(negedge clk);
    chk(err_seen == 1, "R8 glitch no error", err_seen, 1);
    chk(rx_data == 8'h81, "R8 glitch no frame", rx_data, 8'h81);

    chk(exp_q.size() == 0, "R5 all expected irqs seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule